// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This block sits between an 8-bit CPU with a 16-bit address bus and 256 KB of static RAM built from four 64 KB banks. The logical address space is cut into sixteen 4 KB pages. A map of sixteen entries, one per logical page, names the bank and the 4 KB block behind each page. Any block of any bank can therefore appear at any logical slot. The CPU reloads entries through an I/O write to a small port range. A supervisor has its own write port into the same map.

Translation is combinational. The top four CPU address bits pick a map entry. The unit drives the full 18-bit physical address, one active-high chip enable per bank and the gated RAM write strobe. A protection latch, set once by the supervisor after boot, turns block 0 of every bank read-only. This keeps the restart and interrupt handlers in that block safe from stray writes. A blocked write never reaches RAM, and it raises a sticky violation flag that stays readable.

Top module: `pgmap_unit`

## Requirements
- R1: After reset every map entry i holds bank 0, block i, so logical page i reaches bank 0, block i.
- R2: A map entry is 6 bits: bits [5:4] are the bank and bits [3:0] are the block. `phys_addr` equals the entry of page `cpu_addr[15:12]` concatenated with `cpu_addr[11:0]`.
- R3: `bank_ce` is active high and one-hot. Bit b is set only while `cpu_mem_req` is high and the selected entry names bank b. With no request, all enables are low.
- R4: An I/O write (`cpu_io_wr` high) with `cpu_addr[7:4]` equal to the parameter `IO_PORT_SEL` (default 4'hA) loads `cpu_io_data` into entry `cpu_addr[3:0]`. The new mapping applies from the next cycle.
- R5: An I/O write whose `cpu_addr[7:4]` differs from `IO_PORT_SEL` leaves the map unchanged.
- R6: A supervisor write (`sup_wr_en`) loads `sup_wr_data` into entry `sup_wr_idx` from the next cycle. When it falls in the same cycle as a CPU map write, only the supervisor write takes effect.
- R7: A `sup_lock_set` pulse sets `lock_active` from the next cycle. The latch then stays set until reset.
- R8: While `lock_active` is high, a memory write to a page mapped to block 0 of any bank raises `wr_blocked` and keeps `ram_we` low. Reads of that page and writes to other blocks are unaffected.
- R9: A blocked write sets `viol_flag` from the next cycle. The flag holds until a `sup_viol_clr` cycle with no blocked write. When both happen in the same cycle, setting wins. Writes to block 0 before the lock is set raise no violation.
- R10: `ram_we` is high exactly when `cpu_mem_req` and `cpu_mem_wr` are both high and the write is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address; low byte selects the I/O port |
| cpu_mem_req | input | 1 | Memory cycle in progress |
| cpu_mem_wr | input | 1 | Memory cycle is a write |
| cpu_io_wr | input | 1 | I/O write strobe, one cycle |
| cpu_io_data | input | 6 | Map value carried by the I/O write |
| sup_wr_en | input | 1 | Supervisor map write |
| sup_wr_idx | input | 4 | Supervisor entry index |
| sup_wr_data | input | 6 | Supervisor map value |
| sup_lock_set | input | 1 | Set the base-block protection latch |
| sup_viol_clr | input | 1 | Clear the violation flag |
| phys_addr | output | 18 | Physical address {bank, block, offset} |
| bank_ce | output | 4 | Per-bank chip enable, active high |
| ram_we | output | 1 | Gated RAM write strobe |
| wr_blocked | output | 1 | Current write hits a protected block |
| lock_active | output | 1 | Protection latch state |
| viol_flag | output | 1 | Sticky protected-write violation |

## Verification
The bench first walks all sixteen pages right after reset. A design with a wrong identity map or a shifted page index would send some page to the wrong block or bank. It then remaps a page into bank 3 and checks that only that bank's enable rises. A decoder that is not one-hot would enable two banks and corrupt the shared data lines. It fires an I/O write one port range away and a simultaneous supervisor and CPU write to one entry. A loose port decode or a wrong priority would change the map. Finally it arms the lock and writes to block 0 in two different banks. It also reads block 0, clears the flag and writes a normal block. A guard that ignores the bank, blocks reads, lets the strobe through, or loses the flag on clear would each show a wrong `ram_we` or `viol_flag`.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    localparam int CPU_AW     = 16;
    localparam int PAGE_IDX_W = 4;
    localparam int OFFSET_W   = CPU_AW - PAGE_IDX_W;
    localparam int NUM_PAGES  = 1 << PAGE_IDX_W;
    localparam int BANK_W     = 2;
    localparam int NUM_BANKS  = 1 << BANK_W;
    localparam int BLOCK_W    = 4;
    localparam int ENTRY_W    = BANK_W + BLOCK_W;
    localparam int PHYS_AW    = ENTRY_W + OFFSET_W;
    localparam int PORT_NIB_W = 4;

    typedef struct packed {
        logic [BANK_W-1:0]  bank;
        logic [BLOCK_W-1:0] block;
    } map_entry_t;

    typedef struct packed {
        logic                  en;
        logic [PAGE_IDX_W-1:0] idx;
        map_entry_t            val;
    } map_wr_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_SUP  = 2'd2
    } wr_src_e;

    function automatic map_entry_t identity_entry(input int unsigned page);
        map_entry_t e;
        e.bank  = '0;
        e.block = BLOCK_W'(page);
        return e;
    endfunction

    function automatic logic is_base_block(input map_entry_t e);
        return (e.block == '0);
    endfunction

endpackage

// File: rtl/pgmap_regfile.sv
module pgmap_regfile
    import pgmap_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  map_wr_t                      cpu_wr,
    input  map_wr_t                      sup_wr,
    output map_entry_t [NUM_PAGES-1:0]   map_q
);

    wr_src_e src;
    map_wr_t sel_wr;

    // supervisor has priority over the CPU
    always_comb begin
        if (sup_wr.en)      src = SRC_SUP;
        else if (cpu_wr.en) src = SRC_CPU;
        else                src = SRC_NONE;
    end

    always_comb begin
        case (src)
            SRC_SUP: sel_wr = sup_wr;
            SRC_CPU: sel_wr = cpu_wr;
            default: sel_wr = '0;
        endcase
    end

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                map_q[p] <= identity_entry(p);
            else if (sel_wr.en && (sel_wr.idx == PAGE_IDX_W'(p)))
                map_q[p] <= sel_wr.val;
        end
    end

endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
(
    input  map_entry_t [NUM_PAGES-1:0] map_q,
    input  logic [CPU_AW-1:0]          cpu_addr,
    input  logic                       mem_req,
    output map_entry_t                 cur,
    output logic [PHYS_AW-1:0]         phys_addr,
    output logic [NUM_BANKS-1:0]       bank_ce
);

    logic [PAGE_IDX_W-1:0] page;

    assign page      = cpu_addr[CPU_AW-1 -: PAGE_IDX_W];
    assign cur       = map_q[page];
    assign phys_addr = {cur, cpu_addr[OFFSET_W-1:0]};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ce
        assign bank_ce[b] = mem_req && (cur.bank == BANK_W'(b));
    end

endmodule

// File: rtl/pgmap_guard.sv
module pgmap_guard
    import pgmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_set,
    input  logic       viol_clr,
    input  logic       mem_req,
    input  logic       mem_wr,
    input  map_entry_t cur,
    output logic       lock_q,
    output logic       blocked,
    output logic       ram_we,
    output logic       viol_q
);

    logic wr_cycle;

    assign wr_cycle = mem_req && mem_wr;
    assign blocked  = wr_cycle && lock_q && is_base_block(cur);
    assign ram_we   = wr_cycle && !blocked;

    always_ff @(posedge clk) begin
        if (rst)           lock_q <= 1'b0;
        else if (lock_set) lock_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           viol_q <= 1'b0;
        else if (blocked)  viol_q <= 1'b1;
        else if (viol_clr) viol_q <= 1'b0;
    end

endmodule

// File: rtl/pgmap_unit.sv
module pgmap_unit
    import pgmap_pkg::*;
#(
    parameter logic [PORT_NIB_W-1:0] IO_PORT_SEL = 4'hA
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CPU_AW-1:0]      cpu_addr,
    input  logic                   cpu_mem_req,
    input  logic                   cpu_mem_wr,
    input  logic                   cpu_io_wr,
    input  logic [ENTRY_W-1:0]     cpu_io_data,
    input  logic                   sup_wr_en,
    input  logic [PAGE_IDX_W-1:0]  sup_wr_idx,
    input  logic [ENTRY_W-1:0]     sup_wr_data,
    input  logic                   sup_lock_set,
    input  logic                   sup_viol_clr,
    output logic [PHYS_AW-1:0]     phys_addr,
    output logic [NUM_BANKS-1:0]   bank_ce,
    output logic                   ram_we,
    output logic                   wr_blocked,
    output logic                   lock_active,
    output logic                   viol_flag
);

    map_wr_t                    cpu_wr;
    map_wr_t                    sup_wr;
    map_entry_t [NUM_PAGES-1:0] map_q;
    map_entry_t                 cur;

    assign cpu_wr.en  = cpu_io_wr &&
                        (cpu_addr[PAGE_IDX_W +: PORT_NIB_W] == IO_PORT_SEL);
    assign cpu_wr.idx = cpu_addr[PAGE_IDX_W-1:0];
    assign cpu_wr.val = map_entry_t'(cpu_io_data);

    assign sup_wr.en  = sup_wr_en;
    assign sup_wr.idx = sup_wr_idx;
    assign sup_wr.val = map_entry_t'(sup_wr_data);

    pgmap_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .cpu_wr (cpu_wr),
        .sup_wr (sup_wr),
        .map_q  (map_q)
    );

    pgmap_xlate u_xlate (
        .map_q     (map_q),
        .cpu_addr  (cpu_addr),
        .mem_req   (cpu_mem_req),
        .cur       (cur),
        .phys_addr (phys_addr),
        .bank_ce   (bank_ce)
    );

    pgmap_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .lock_set (sup_lock_set),
        .viol_clr (sup_viol_clr),
        .mem_req  (cpu_mem_req),
        .mem_wr   (cpu_mem_wr),
        .cur      (cur),
        .lock_q   (lock_active),
        .blocked  (wr_blocked),
        .ram_we   (ram_we),
        .viol_q   (viol_flag)
    );

endmodule

// File: rtl/pgmap_chk.sv
module pgmap_chk
    import pgmap_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [CPU_AW-1:0]    cpu_addr,
    input logic                 cpu_mem_req,
    input logic                 cpu_mem_wr,
    input logic                 sup_viol_clr,
    input logic [PHYS_AW-1:0]   phys_addr,
    input logic [NUM_BANKS-1:0] bank_ce,
    input logic                 ram_we,
    input logic                 wr_blocked,
    input logic                 lock_active,
    input logic                 viol_flag
);

    // R1
    identity_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && cpu_mem_req) |->
        (phys_addr[PHYS_AW-1 -: ENTRY_W] == {{BANK_W{1'b0}}, cpu_addr[CPU_AW-1 -: PAGE_IDX_W]}));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFFSET_W-1:0] == cpu_addr[OFFSET_W-1:0]);

    // R3
    ce_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_ce));

    // R3
    ce_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_mem_req |-> (bank_ce == '0));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_active |=> lock_active);

    // R8
    blocked_no_we_chk: assert property (@(posedge clk) disable iff (rst)
        wr_blocked |-> !ram_we);

    // R8
    blocked_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        wr_blocked |-> lock_active);

    // R9
    viol_sets_chk: assert property (@(posedge clk) disable iff (rst)
        wr_blocked |=> viol_flag);

    // R9
    viol_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !sup_viol_clr) |=> viol_flag);

    // R10
    we_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cpu_mem_req && cpu_mem_wr));

endmodule

bind pgmap_unit pgmap_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_mem_req  (cpu_mem_req),
    .cpu_mem_wr   (cpu_mem_wr),
    .sup_viol_clr (sup_viol_clr),
    .phys_addr    (phys_addr),
    .bank_ce      (bank_ce),
    .ram_we       (ram_we),
    .wr_blocked   (wr_blocked),
    .lock_active  (lock_active),
    .viol_flag    (viol_flag)
);

// File: tb/sim_pgmap_unit.sv
module sim_pgmap_unit;
    import pgmap_pkg::*;

    localparam time CLK_P = 10;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [CPU_AW-1:0]     cpu_addr = '0;
    logic                  cpu_mem_req = 1'b0;
    logic                  cpu_mem_wr = 1'b0;
    logic                  cpu_io_wr = 1'b0;
    logic [ENTRY_W-1:0]    cpu_io_data = '0;
    logic                  sup_wr_en = 1'b0;
    logic [PAGE_IDX_W-1:0] sup_wr_idx = '0;
    logic [ENTRY_W-1:0]    sup_wr_data = '0;
    logic                  sup_lock_set = 1'b0;
    logic                  sup_viol_clr = 1'b0;
    logic [PHYS_AW-1:0]    phys_addr;
    logic [NUM_BANKS-1:0]  bank_ce;
    logic                  ram_we;
    logic                  wr_blocked;
    logic                  lock_active;
    logic                  viol_flag;

    always #(CLK_P/2) clk = ~clk;

    pgmap_unit u0 (.*);

    typedef struct {
        logic [PHYS_AW-1:0]   phys;
        logic [NUM_BANKS-1:0] ce;
        logic                 we;
        logic                 blk;
        logic                 lock;
        logic                 viol;
        string                req;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench reference state
    logic [ENTRY_W-1:0] m_map [NUM_PAGES];
    logic m_lock;
    logic m_viol;

    task automatic model_reset();
        for (int i = 0; i < NUM_PAGES; i++) m_map[i] = ENTRY_W'(i);
        m_lock = 1'b0;
        m_viol = 1'b0;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one bus cycle: drive, predict, push, then advance the model past the edge
    task automatic cyc(input logic [CPU_AW-1:0] addr, input logic mreq, input logic mwr,
                       input logic iowr, input logic [ENTRY_W-1:0] iodata,
                       input logic sen, input logic [PAGE_IDX_W-1:0] sidx,
                       input logic [ENTRY_W-1:0] sval,
                       input logic lset, input logic vclr, input string req);
        exp_t e;
        logic [ENTRY_W-1:0] ent;
        logic blk;
        cpu_addr = addr; cpu_mem_req = mreq; cpu_mem_wr = mwr;
        cpu_io_wr = iowr; cpu_io_data = iodata;
        sup_wr_en = sen; sup_wr_idx = sidx; sup_wr_data = sval;
        sup_lock_set = lset; sup_viol_clr = vclr;
        ent = m_map[addr[15:12]];
        blk = m_lock && mreq && mwr && (ent[3:0] == 4'h0);
        e.phys = {ent, addr[11:0]};
        e.ce   = mreq ? NUM_BANKS'(1 << ent[5:4]) : '0;
        e.we   = mreq && mwr && !blk;
        e.blk  = blk;
        e.lock = m_lock;
        e.viol = m_viol;
        e.req  = req;
        sb.push_back(e);
        @(posedge clk);
        if (sen) m_map[sidx] = sval;
        else if (iowr && addr[7:4] == 4'hA) m_map[addr[3:0]] = iodata;
        if (lset) m_lock = 1'b1;
        if (blk) m_viol = 1'b1;
        else if (vclr) m_viol = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [CPU_AW-1:0] a, input string req);
        cyc(a, 1, 0, 0, '0, 0, '0, '0, 0, 0, req);
    endtask
    task automatic wr(input logic [CPU_AW-1:0] a, input string req);
        cyc(a, 1, 1, 0, '0, 0, '0, '0, 0, 0, req);
    endtask
    task automatic idle(input string req);
        cyc(16'h0000, 0, 0, 0, '0, 0, '0, '0, 0, 0, req);
    endtask

    // monitor: compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, "phys_addr", 32'(phys_addr), 32'(e.phys));
                chk(e.req, "bank_ce", 32'(bank_ce), 32'(e.ce));
                chk(e.req, "ram_we", 32'(ram_we), 32'(e.we));
                chk(e.req, "wr_blocked", 32'(wr_blocked), 32'(e.blk));
                chk(e.req, "lock_active", 32'(lock_active), 32'(e.lock));
                chk(e.req, "viol_flag", 32'(viol_flag), 32'(e.viol));
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 identity map after reset, R2 address composition
        for (int p = 0; p < NUM_PAGES; p++)
            rd(CPU_AW'((p << 12) | 12'h5A3), "R1/R2 identity read");
        // R3 no request -> no enables
        idle("R3 idle");
        // R4 port write: entry 3 <- bank3 block6
        cyc(16'h00A3, 0, 0, 1, 6'h36, 0, '0, '0, 0, 0, "R4 io map write");
        rd(16'h3FFF, "R4/R3 remapped page in bank3");
        // R5 port one range away ignored
        cyc(16'h00B3, 0, 0, 1, 6'h11, 0, '0, '0, 0, 0, "R5 off-range io");
        rd(16'h3001, "R5 map unchanged");
        // R6 supervisor wins a same-cycle conflict
        cyc(16'h00A5, 0, 0, 1, 6'h01, 1, 4'h5, 6'h2C, 0, 0, "R6 conflict");
        rd(16'h5123, "R6 supervisor value");
        cyc(16'h0000, 0, 0, 0, '0, 1, 4'h9, 6'h1F, 0, 0, "R6 sup write");
        rd(16'h9000, "R6 sup entry in bank1");
        // R10 writes before lock pass; R9 no violation unlocked
        wr(16'h3010, "R10 write remapped");
        wr(16'h0010, "R9/R10 base write unlocked");
        idle("R9 no violation unlocked");
        // R7 arm the lock
        cyc(16'h0000, 0, 0, 0, '0, 0, '0, '0, 1, 0, "R7 lock set");
        idle("R7 lock active");
        // R8 blocked base write in bank0
        wr(16'h0123, "R8 base write bank0");
        rd(16'h0123, "R9/R8 base read after violation");
        // R8 base block of bank2
        cyc(16'h0000, 0, 0, 0, '0, 1, 4'h7, 6'h20, 0, 0, "R8 map page7 to bank2 block0");
        wr(16'h7444, "R8 base write bank2");
        // R9 clear
        cyc(16'h0000, 0, 0, 0, '0, 0, '0, '0, 0, 1, "R9 clear");
        idle("R9 cleared, R7 lock held");
        // R9 clear and blocked write together -> set wins
        cyc(16'h7000, 1, 1, 0, '0, 0, '0, '0, 0, 1, "R9 clear vs blocked");
        idle("R9 set wins");
        // R8 other blocks unaffected under lock
        wr(16'h5ABC, "R8/R10 non-base write under lock");
        wr(16'h3ABC, "R8/R10 bank3 write under lock");
        idle("R3 final idle");

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule